// File: doc/BRIEF.md
# Serial SRAM Access Sequencer

This block turns one host request (a read or a write of a single byte at a 16-bit address) into a complete transaction on a four-wire serial bus to an external serial SRAM. It owns the chip-select line and keeps it low for the whole transaction. It shifts out the opcode, the two address bytes and a data byte. For a read, that last byte is a dummy byte, and the byte clocked in during it is returned to the host.

Requests arrive on a valid/ready port. The host raises `req_valid` with the fields held stable until the cycle in which `req_ready` is also high. The request is taken on that clock edge. `req_ready` is simply the inverse of `busy`, so the host sees back-pressure for the whole transaction. The result comes back as a one-cycle `done` pulse with `rd_data`. The shifter works in clock mode 0, most significant bit first, with an SCK half period set by a parameter. A deselect gap of a parameterised length (at least two clocks) follows every transaction.

Top module: `sram_serial_seq`

## Requirements
- R1: A write request produces one frame: `spi_cs_n` falls, then 0x02, address bits 15:8, address bits 7:0 and the write byte are sent, then `spi_cs_n` rises.
- R2: A read request produces one frame with 0x03, address high byte, address low byte and a dummy 0x00. The 8 bits sampled on `spi_miso` during the fourth byte, MSB first, appear on `rd_data` when `done` pulses.
- R3: `spi_cs_n` stays low without a break from the first to the last bit of a frame, and each frame has exactly 32 SCK rising edges.
- R4: Mode 0, MSB first. SCK idles low, it is low whenever `spi_cs_n` is high, and `spi_mosi` changes only after a falling SCK edge or before the first rising edge of a byte.
- R5: Between two frames `spi_cs_n` stays high for at least GAP_CYCLES system clocks, and GAP_CYCLES is never taken as less than 2.
- R6: `req_ready` equals `!busy`. `busy` rises the cycle after a handshake and stays high until the cycle in which `done` pulses. `done` is high for exactly one cycle, and `busy` is low in that cycle.
- R7: A request presented while `busy` is high is not taken. It starts no frame and changes no memory location.
- R8: `done` pulses only while `spi_cs_n` is high. After a write, `rd_data` keeps its previous value, so the byte shifted in during a write is dropped.
- R9: After reset, `spi_cs_n`=1, `spi_sck`=0, `busy`=0, `done`=0, `req_ready`=1 and `rd_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken (inverse of busy) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 8 | Byte to write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte returned by the last read |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to memory |
| spi_miso | input | 1 | Serial data from memory |

## Verification
A wrong byte index or wrong opcode choice shows up in the bench's bus decoder as a wrong byte when chip select rises, at the end of the first frame that goes wrong. A shifter that miscounts bits shows up as a frame of other than 32 edges, or as a read byte shifted by one position. A sequencer that releases chip select early, or shortens the gap, breaks the per-clock cs/sck and gap checks within a few cycles. A wrong busy state shows up against the bench's handshake model on the next clock.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] DUMMY    = 8'h00;
  localparam int unsigned FRAME_BYTES = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_WAIT = 2'd2,
    ST_GAP  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/sram_spi_shifter.sv
module sram_spi_shifter #(
  parameter int unsigned SCK_HALF = 2,
  parameter int unsigned BYTE_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              xfer_done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);
  localparam int unsigned DIV_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam int unsigned BIT_W = $clog2(BYTE_W);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCK_HALF - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);

  logic              active;
  logic [DIV_W-1:0]  div_cnt;
  logic [BIT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] tx_sh;

  assign mosi = tx_sh[BYTE_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      div_cnt   <= '0;
      bit_cnt   <= '0;
      tx_sh     <= '0;
      rx_byte   <= '0;
      sck       <= 1'b0;
      xfer_done <= 1'b0;
    end else begin
      xfer_done <= 1'b0;
      if (!active) begin
        if (start) begin
          active  <= 1'b1;
          tx_sh   <= tx_byte;
          div_cnt <= '0;
          bit_cnt <= '0;
          sck     <= 1'b0;
        end
      end else if (div_cnt == DIV_LAST) begin
        div_cnt <= '0;
        if (!sck) begin
          sck     <= 1'b1;
          rx_byte <= {rx_byte[BYTE_W-2:0], miso};
        end else begin
          sck <= 1'b0;
          if (bit_cnt == BIT_LAST) begin
            active    <= 1'b0;
            xfer_done <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
            tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
          end
        end
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end

  // R4
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sck);
  // R4
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$fell(sck)) |-> $stable(mosi));
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int unsigned GAP_CYCLES = 3,
  parameter int unsigned ADDR_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              busy,
  output logic              done,
  output logic [7:0]        rd_data,
  output logic              cs_n,
  output logic              eng_start,
  output logic [7:0]        eng_tx,
  input  logic              eng_done,
  input  logic [7:0]        eng_rx
);
  localparam int unsigned GAP_EFF = (GAP_CYCLES < 2) ? 2 : GAP_CYCLES;
  localparam int unsigned GAP_W   = $clog2(GAP_EFF);
  localparam int unsigned IDX_W   = $clog2(FRAME_BYTES);
  localparam int unsigned FRAME_W = 8 * FRAME_BYTES;
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_EFF - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BYTES - 1);

  seq_state_t         st;
  logic [IDX_W-1:0]   idx;
  logic [GAP_W-1:0]   gap_cnt;
  logic [FRAME_W-1:0] frame;
  logic               is_write;

  assign busy      = (st != ST_IDLE);
  assign eng_start = (st == ST_LOAD);

  always_comb begin
    eng_tx = '0;
    for (int b = 0; b < FRAME_BYTES; b++) begin
      if (idx == IDX_W'(b)) eng_tx = frame[FRAME_W-1-8*b -: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      idx      <= '0;
      gap_cnt  <= '0;
      frame    <= '0;
      is_write <= 1'b0;
      cs_n     <= 1'b1;
      done     <= 1'b0;
      rd_data  <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: if (req_valid) begin
          is_write <= req_write;
          frame    <= {(req_write ? OP_WRITE : OP_READ), 16'(req_addr),
                       (req_write ? req_wdata : DUMMY)};
          idx      <= '0;
          cs_n     <= 1'b0;
          st       <= ST_LOAD;
        end
        ST_LOAD: st <= ST_WAIT;
        ST_WAIT: if (eng_done) begin
          if (idx == IDX_LAST) begin
            cs_n    <= 1'b1;
            gap_cnt <= '0;
            st      <= ST_GAP;
            if (!is_write) rd_data <= eng_rx;
          end else begin
            idx <= idx + 1'b1;
            st  <= ST_LOAD;
          end
        end
        ST_GAP: if (gap_cnt == GAP_LAST) begin
          st   <= ST_IDLE;
          done <= 1'b1;
        end else begin
          gap_cnt <= gap_cnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3
  cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOAD || st == ST_WAIT) |-> !cs_n);
  // R8
  done_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && $past(cs_n)));
  // R5
  gap_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> cs_n);
  // R7
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(frame));
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/sram_serial_seq.sv
module sram_serial_seq #(
  parameter int unsigned SCK_HALF   = 2,
  parameter int unsigned GAP_CYCLES = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [15:0] req_addr,
  input  logic [7:0]  req_wdata,
  output logic        busy,
  output logic        done,
  output logic [7:0]  rd_data,
  output logic        spi_cs_n,
  output logic        spi_sck,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  logic       eng_start, eng_done;
  logic [7:0] eng_tx, eng_rx;

  assign req_ready = !busy;

  sram_seq_ctrl #(.GAP_CYCLES(GAP_CYCLES), .ADDR_W(16)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rd_data(rd_data), .cs_n(spi_cs_n),
    .eng_start(eng_start), .eng_tx(eng_tx),
    .eng_done(eng_done), .eng_rx(eng_rx)
  );

  sram_spi_shifter #(.SCK_HALF(SCK_HALF), .BYTE_W(8)) shift_i (
    .clk(clk), .rst_n(rst_n),
    .start(eng_start), .tx_byte(eng_tx),
    .xfer_done(eng_done), .rx_byte(eng_rx),
    .sck(spi_sck), .mosi(spi_mosi), .miso(spi_miso)
  );

  // R4
  sck_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);
endmodule

// File: tb/sram_serial_seq_tb.sv
module sram_serial_seq_tb_top;
  localparam int HALF = 2;
  localparam int GAP  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, busy, done, spi_cs_n, spi_sck, spi_mosi;
  logic spi_miso = 1'b0;
  logic [7:0] rd_data;

  always #10 clk = ~clk;

  sram_serial_seq #(.SCK_HALF(HALF), .GAP_CYCLES(GAP)) dut_i (.*);

  int n_checks = 0, n_fail = 0;
  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural memory on the serial bus
  logic [7:0] mem [int];
  logic [7:0] frm_q [$];
  int  rises = 0, frames = 0;
  logic [7:0] sh_in = '0, rd_out = '0;
  logic [7:0] last_frame [$];
  int last_bits = 0;

  function automatic logic [7:0] mem_rd(input int a);
    return mem.exists(a) ? mem[a] : 8'hEE;
  endfunction

  always @(negedge spi_cs_n) begin
    rises = 0; frm_q = {};
  end
  always @(posedge spi_sck) if (!spi_cs_n) begin
    sh_in = {sh_in[6:0], spi_mosi};
    rises++;
    if (rises % 8 == 0) frm_q.push_back(sh_in);
  end
  always @(negedge spi_sck) if (!spi_cs_n && frm_q.size() >= 3 && frm_q[0] == 8'h03) begin
    if (rises == 24) rd_out = mem_rd({frm_q[1], frm_q[2]});
    if (rises >= 24 && rises < 32) spi_miso = rd_out[7 - (rises - 24)];
  end
  always @(posedge spi_cs_n) if (rst_n) begin
    frames++;
    last_frame = frm_q;
    last_bits = rises;
    if (frm_q.size() == 4 && frm_q[0] == 8'h02) mem[{frm_q[1], frm_q[2]}] = frm_q[3];
  end

  // per-clock model of handshake/busy and bus idle rules
  bit mbusy = 0, hs = 0;
  int hi_cnt = 0, cycles = 0;
  bit started = 0;
  always @(posedge clk) begin
    hs = rst_n && req_valid && req_ready;
    if (rst_n) cycles++;
  end
  always @(negedge clk) if (rst_n) begin
    if (hs) mbusy = 1;
    if (done) begin
      check(!busy, "R6 busy low with done", busy, 0);
      check(spi_cs_n, "R8 done while deselected", spi_cs_n, 1);
      mbusy = 0;
    end else if (busy !== mbusy) check(0, "R6 busy vs model", busy, mbusy);
    if (req_ready !== !busy) check(0, "R6 ready=!busy", req_ready, !busy);
    if (spi_cs_n && spi_sck) check(0, "R4 sck low when deselected", spi_sck, 0);
    if (spi_cs_n) hi_cnt++;
    else begin
      if (hi_cnt > 0 && started) check(hi_cnt >= GAP, "R5 deselect gap", hi_cnt, GAP);
      if (hi_cnt > 0) started = 1;
      hi_cnt = 0;
    end
  end

  task automatic issue(input bit w, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    do @(posedge clk); while (!req_ready);
    @(negedge clk);
    req_valid = 0;
    while (!done) @(negedge clk);
  endtask

  task automatic chk_frame(input string req, input logic [7:0] op,
                           input logic [15:0] a, input logic [7:0] d);
    check(last_bits == 32, {req, " R3 edge count"}, last_bits, 32);
    check(last_frame.size() == 4 && last_frame[0] == op && last_frame[1] == a[15:8]
          && last_frame[2] == a[7:0] && last_frame[3] == d, {req, " frame"},
          (last_frame.size() == 4) ? {last_frame[0], last_frame[1], last_frame[2], last_frame[3]} : 0,
          {op, a, d});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(spi_cs_n == 1 && spi_sck == 0 && busy == 0 && done == 0 && req_ready == 1 && rd_data == 0,
          "R9 reset", {spi_cs_n, spi_sck, busy, done, req_ready}, 5'b10001);
    rst_n = 1;
    repeat (2) @(negedge clk);

    issue(1, 16'h1234, 8'hA5); chk_frame("R1 w1", 8'h02, 16'h1234, 8'hA5);
    issue(1, 16'h0000, 8'hFF); chk_frame("R1 w2", 8'h02, 16'h0000, 8'hFF);
    issue(1, 16'hFFFF, 8'h00); chk_frame("R1 w3", 8'h02, 16'hFFFF, 8'h00);

    issue(0, 16'h1234, 8'h77); chk_frame("R2 r1", 8'h03, 16'h1234, 8'h00);
    check(rd_data == 8'hA5, "R2 read data 1234", rd_data, 8'hA5);
    issue(0, 16'h0000, 8'h00);
    check(rd_data == 8'hFF, "R2 read data 0000", rd_data, 8'hFF);
    issue(0, 16'hFFFF, 8'h00);
    check(rd_data == 8'h00, "R2 read data FFFF", rd_data, 8'h00);
    issue(0, 16'h8001, 8'h00);
    check(rd_data == 8'hEE, "R2 read unwritten", rd_data, 8'hEE);

    // R8: write leaves rd_data alone
    issue(1, 16'h4242, 8'h3C);
    check(rd_data == 8'hEE, "R8 rd_data kept after write", rd_data, 8'hEE);

    // R7: request while busy ignored
    begin
      int f0;
      f0 = frames;
      @(negedge clk);
      req_valid = 1; req_write = 1; req_addr = 16'h5555; req_wdata = 8'h11;
      @(posedge clk); @(negedge clk);
      req_write = 1; req_addr = 16'h6666; req_wdata = 8'h99;
      repeat (10) @(negedge clk);
      req_valid = 0;
      while (!done) @(negedge clk);
      check(frames == f0 + 1, "R7 one frame only", frames - f0, 1);
      chk_frame("R7 first request kept", 8'h02, 16'h5555, 8'h11);
      issue(0, 16'h6666, 8'h00);
      check(rd_data == 8'hEE, "R7 ignored write had no effect", rd_data, 8'hEE);
      issue(0, 16'h5555, 8'h00);
      check(rd_data == 8'h11, "R7 accepted write stored", rd_data, 8'h11);
    end

    // back-to-back pattern
    for (int i = 0; i < 4; i++) issue(1, 16'(16'h0100 + i * 16'h0101), 8'(8'h30 + i));
    for (int i = 0; i < 4; i++) begin
      issue(0, 16'(16'h0100 + i * 16'h0101), 8'h00);
      check(rd_data == 8'(8'h30 + i), "R2 burst readback", rd_data, 8'h30 + i);
    end
    repeat (5) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule